// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into the oversampling tick that paces a serial transmitter and receiver. A single 32-bit scale word sets the divisor as a whole number of clocks plus a fraction counted in sixty-fourths of a clock. The whole part sets the base tick period, and a 6-bit phase accumulator stretches some periods by one clock, so that over time the average tick period equals the exact divisor rather than its rounded value.

Next to the sample tick, the block gives a bit-time strobe that marks every sixteenth tick, or every eighth when the low-oversampling select is set. Software computes the scale word as round(64 x f_clk / (baud x ratio)) and writes it. Each write restarts the tick phase from zero. A whole part of zero, or a low enable, stops the ticks.

Top module: `frac_baud_tick`

## Requirements
- R1: The scale word splits into a whole part in bits [31:6] and a fraction in bits [5:0], counted in sixty-fourths of a clock.
- R2: Let a restart edge be the clock edge that captures a scale write or the last edge of reset or disable, with whole part W >= 1 and fraction F. Then sample tick number n (n = 1, 2, ...) is high in the cycle that follows edge n*W + floor(n*F/64) after that restart edge, and in no other cycle.
- R3: Between two ticks that follow one another with no restart between them, the distance is either W or W+1 clocks.
- R4: With ovs8_sel = 0, bit_strobe is high together with every 16th tick after a restart, and never without a tick.
- R5: With ovs8_sel = 1, bit_strobe is high together with every 8th tick after a restart.
- R6: When the whole part is 0, no tick and no strobe are produced, whatever the fraction is.
- R7: While enable is low, both outputs stay low and the phase is cleared. The first edge with enable high counts as edge 1 after a restart.
- R8: A scale write clears the period counter, the accumulator and the tick count. Both outputs are low in the cycle after the write edge.
- R9: During reset both outputs are low. After reset the scale word is round(64 x CLK_HZ / (BAUD x 16)), which is 1736 (W = 27, F = 8) for 50 MHz and 115200 baud.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Tick generation enable; low clears the phase |
| ovs8_sel | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| scale_we | input | 1 | Write strobe for the scale word |
| scale_wdata | input | 32 | New scale word: whole in [31:6], fraction in [5:0] |
| sample_tick | output | 1 | One-cycle oversampling tick |
| bit_strobe | output | 1 | One-cycle bit-time strobe, coincident with a tick |

## Verification
A wrong period counter or accumulator shows up at the very next tick: the tick lands one or more clocks off the n*W + floor(n*F/64) schedule, and the bench compares every cycle against that schedule. A carry that is lost or doubled only shows after several ticks, so each fraction from 0 to 63 is swept over at least 17 ticks. A wrong tick count shows up at the 8th or 16th tick as a strobe that is missing or misplaced. Restart faults show in the first tick after a write, a disable or reset.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

    localparam int SCALE_W = 32;
    localparam int FRAC_W  = 6;
    localparam int WHOLE_W = SCALE_W - FRAC_W;

    typedef struct packed {
        logic [WHOLE_W-1:0] whole;
        logic [FRAC_W-1:0]  frac;
    } scale_t;

    typedef enum logic {
        OVS_HIGH = 1'b0,
        OVS_LOW  = 1'b1
    } ovs_e;

    // Rounded divisor in sixty-fourths of a clock.
    function automatic logic [SCALE_W-1:0] scale_from_rate(
        input longint clk_hz,
        input longint baud,
        input longint ratio
    );
        longint q;
        q = (clk_hz * (longint'(1) << (FRAC_W + 1))) / (baud * ratio);
        q = (q + 1) >>> 1;
        return q[SCALE_W-1:0];
    endfunction

endpackage

// File: rtl/fbt_scale_reg.sv
module fbt_scale_reg
    import fbt_pkg::*;
#(
    parameter logic [SCALE_W-1:0] RESET_SCALE = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SCALE_W-1:0] wdata,
    output scale_t             scale_q,
    output logic               restart
);

    always_ff @(posedge clk) begin
        if (rst) begin
            scale_q <= scale_t'(RESET_SCALE);
        end else if (we) begin
            scale_q <= scale_t'(wdata);
        end
    end

    // A write restarts the phase in the same edge that loads the word.
    assign restart = we;

endmodule

// File: rtl/fbt_phase.sv
module fbt_phase
    import fbt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [WHOLE_W-1:0] whole,
    input  logic [FRAC_W-1:0]  frac,
    output logic               hit
);

    logic [WHOLE_W-1:0] cnt_q;
    logic [FRAC_W-1:0]  acc_q;
    logic [FRAC_W:0]    sum;
    logic [WHOLE_W-1:0] limit;

    // Carry out of the accumulator stretches the current period by one clock.
    assign sum   = {1'b0, acc_q} + {1'b0, frac};
    assign limit = whole - WHOLE_W'(1) + WHOLE_W'(sum[FRAC_W]);
    assign hit   = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (hit) begin
            cnt_q <= '0;
            acc_q <= sum[FRAC_W-1:0];
        end else begin
            cnt_q <= cnt_q + WHOLE_W'(1);
        end
    end

endmodule

// File: rtl/fbt_bit_div.sv
module fbt_bit_div #(
    parameter int HI_TICKS = 16,
    parameter int LO_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hit,
    input  logic sel_low,
    output logic tick_q,
    output logic strobe_q
);

    localparam int CW = (HI_TICKS > 1) ? $clog2(HI_TICKS) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          wrap;

    generate
        if (LO_TICKS == HI_TICKS) begin : g_single
            assign last = CW'(HI_TICKS - 1);
        end else begin : g_dual
            assign last = sel_low ? CW'(LO_TICKS - 1) : CW'(HI_TICKS - 1);
        end
    endgenerate

    // >= keeps the count bounded when the ratio drops mid-stream.
    assign wrap = (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q    <= '0;
            tick_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            tick_q   <= hit;
            strobe_q <= hit && wrap;
            if (hit) begin
                cnt_q <= wrap ? '0 : cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick
    import fbt_pkg::*;
#(
    parameter longint CLK_HZ   = 50_000_000,
    parameter longint BAUD     = 115_200,
    parameter int     HI_TICKS = 16,
    parameter int     LO_TICKS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        ovs8_sel,
    input  logic        scale_we,
    input  logic [31:0] scale_wdata,
    output logic        sample_tick,
    output logic        bit_strobe
);

    localparam logic [SCALE_W-1:0] RESET_SCALE = scale_from_rate(CLK_HZ, BAUD, longint'(HI_TICKS));

    scale_t             scale_q;
    logic               restart;
    logic               run;
    logic               hit;
    logic [WHOLE_W-1:0] scale_whole;
    ovs_e               ovs_mode;

    assign scale_whole = scale_q.whole;
    assign ovs_mode    = ovs_e'(ovs8_sel);
    assign run         = enable && (scale_whole != '0) && !restart;

    fbt_scale_reg #(
        .RESET_SCALE(RESET_SCALE)
    ) scale_i (
        .clk    (clk),
        .rst    (rst),
        .we     (scale_we),
        .wdata  (scale_wdata),
        .scale_q(scale_q),
        .restart(restart)
    );

    fbt_phase phase_i (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .whole(scale_whole),
        .frac (scale_q.frac),
        .hit  (hit)
    );

    fbt_bit_div #(
        .HI_TICKS(HI_TICKS),
        .LO_TICKS(LO_TICKS)
    ) div_i (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .hit     (hit),
        .sel_low (ovs_mode == OVS_LOW),
        .tick_q  (sample_tick),
        .strobe_q(bit_strobe)
    );

endmodule

// File: rtl/fbt_checker.sv
module fbt_checker
    import fbt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               scale_we,
    input logic               sample_tick,
    input logic               bit_strobe,
    input logic [WHOLE_W-1:0] whole
);

    logic             seen_q;
    logic [WHOLE_W:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || scale_we || !enable) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else if (sample_tick) begin
            seen_q <= 1'b1;
            gap_q  <= (WHOLE_W + 1)'(1);
        end else if (gap_q != '1) begin
            gap_q <= gap_q + (WHOLE_W + 1)'(1);
        end
    end

    // R3: tick spacing is the whole part or one more
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (seen_q && sample_tick) |-> (gap_q == {1'b0, whole} || gap_q == {1'b0, whole} + (WHOLE_W + 1)'(1)));

    // R4: strobe only together with a tick
    a_r4_strobe_with_tick: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |-> sample_tick);

    // R2: a tick lasts one cycle when the period is at least two clocks
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && whole > WHOLE_W'(1) && !scale_we) |=> !sample_tick);

    // R6: zero whole part gives no tick
    a_r6_zero_whole: assert property (@(posedge clk) disable iff (rst)
        (whole == '0) |=> !sample_tick);

    // R7: disabled means silent
    a_r7_disable_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!sample_tick && !bit_strobe));

    // R8: write edge leaves both outputs low
    a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
        scale_we |=> (!sample_tick && !bit_strobe));

endmodule

bind frac_baud_tick fbt_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .scale_we   (scale_we),
    .sample_tick(sample_tick),
    .bit_strobe (bit_strobe),
    .whole      (scale_whole)
);

// File: tb/frac_baud_tick_tb_top.sv
`timescale 1ns/1ps
module frac_baud_tick_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic        ovs8_sel = 1'b0;
    logic        scale_we = 1'b0;
    logic [31:0] scale_wdata = '0;
    logic        sample_tick;
    logic        bit_strobe;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    frac_baud_tick dut_i (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .ovs8_sel   (ovs8_sel),
        .scale_we   (scale_we),
        .scale_wdata(scale_wdata),
        .sample_tick(sample_tick),
        .bit_strobe (bit_strobe)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %0b expected %0b", tag, what, $time, act, exp);
        end
    endtask

    // Called right after a restart edge; the next posedge is edge 1.
    task automatic check_window(input int ip, input int fp, input bit o8, input int ncyc, input string tag);
        longint n = 1;
        longint next_t = longint'(ip) + longint'(fp) / 64;
        int per = o8 ? 8 : 16;
        for (int c = 1; c <= ncyc; c++) begin
            bit exp_t;
            bit exp_s;
            @(posedge clk);
            @(negedge clk);
            exp_t = (longint'(c) == next_t);
            exp_s = exp_t && ((n % per) == 0);
            chk(sample_tick, exp_t, tag, "sample_tick");
            chk(bit_strobe, exp_s, o8 ? "R5" : "R4", "bit_strobe");
            if (exp_t) begin
                n++;
                next_t = n * ip + (n * fp) / 64;
            end
        end
    endtask

    task automatic write_scale(input int ip, input int fp);
        @(negedge clk);
        scale_we    = 1'b1;
        scale_wdata = {ip[25:0], fp[5:0]};
        @(posedge clk);
        @(negedge clk);
        scale_we = 1'b0;
        chk(sample_tick, 1'b0, "R8", "tick after write");
        chk(bit_strobe, 1'b0, "R8", "strobe after write");
    endtask

    task automatic expect_quiet(input int ncyc, input string tag);
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            chk(sample_tick, 1'b0, tag, "tick while stopped");
            chk(bit_strobe, 1'b0, tag, "strobe while stopped");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sample_tick, 1'b0, "R9", "tick in reset");
        chk(bit_strobe, 1'b0, "R9", "strobe in reset");
        rst = 1'b0;
        // R9: default word 27 + 8/64, 16x ratio
        check_window(27, 8, 1'b0, 27 * 17 + 10, "R9");

        // R1 R2 R3: sweep every fraction for small whole parts, both ratios
        for (int o = 0; o < 2; o++) begin
            ovs8_sel = o[0];
            for (int ip = 1; ip <= 3; ip++) begin
                for (int fp = 0; fp < 64; fp++) begin
                    write_scale(ip, fp);
                    check_window(ip, fp, o[0], 17 * (ip + 1) + 2, "R1 R2");
                end
            end
        end
        ovs8_sel = 1'b0;

        // R8: write in the middle of a running phase restarts it
        write_scale(5, 37);
        check_window(5, 37, 1'b0, 23, "R8");
        write_scale(7, 50);
        check_window(7, 50, 1'b0, 7 * 18 + 6, "R8");

        // R6: zero whole part with a nonzero fraction stays silent
        write_scale(0, 32);
        expect_quiet(200, "R6");

        // R7: disable clears the phase, re-enable restarts it
        write_scale(4, 0);
        check_window(4, 0, 1'b0, 10, "R7");
        @(negedge clk);
        enable = 1'b0;
        expect_quiet(30, "R7");
        enable = 1'b1;
        check_window(4, 0, 1'b0, 4 * 17 + 3, "R7");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before the end of the run");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule